// File: doc/BRIEF.md
# Dual-Mode Floppy Controller Register Front End

This block is the register-level front end of a floppy disk controller. It decodes accesses from a simple memory bus within an 8 KB window. Each register slot is 512 bytes wide, so the register index is the bus address shifted right by nine bits. After reset the block runs in a legacy mode. In that mode every access, read or write, acts as a soft switch. The index selects one of eight latches, and the lowest index bit gives the value the latch takes. The latches drive the four stepper phases, the motor, the drive select and the two sequencing bits (called Q6 and Q7 here).

In legacy mode, when both sequencing bits are set, a write is captured. It goes to a legacy data register if the motor latch is set, and to a legacy mode register if it is clear. The values written to the legacy mode register feed an unlock detector. When the detector sees the pattern 0x57, 0x17, 0x57, 0x57, the block switches to an enhanced register map and stays in it until reset.

In the enhanced map, the block holds a phase byte and a control byte. The control byte has separate bit-clear and bit-set addresses. A read of the handshake register reports a sense bit when the phase byte holds the drive-present query code. The block does not model drive mechanics, data encoding, the FIFO or the CRC.

Top module: `fdc_regfront`

## Requirements
- R1: The register index is the bus address shifted right by 9 (address bits [12:9]). Address bits [8:0] have no effect.
- R2: In legacy mode, every access with the strobe high sets latch index[3:1] to index[0] on the clock edge. This holds for reads and writes. `sw_latch` bit n shows latch n: bits 0 to 3 are the stepper phases, bit 4 is the motor, bit 5 is the drive select, bit 6 is Q6 and bit 7 is Q7.
- R3: In legacy mode, `rd_data` is always 0x00.
- R4: A legacy write is captured only if Q6 and Q7 are both set once the latch update of that same access has been applied. With the motor latch set, the value loads `leg_data`. With the motor latch clear, it loads `leg_mode` and is presented to the unlock detector. Any other legacy write changes neither register.
- R5: The unlock detector steps through 0x57, 0x17, 0x57, 0x57 on captured legacy mode writes. A value that does not match leaves the step where it is. The fourth match sets `enh_mode` at that clock edge and returns the detector to its first step.
- R6: In enhanced mode, a write to index 4 stores the whole byte as the phase byte. A read of index 12 returns the phase byte.
- R7: In enhanced mode, a read of index 15 returns 0x08 when the phase byte equals 0x77, and 0x00 otherwise.
- R8: In enhanced mode, a write to index 6 clears the bits of `ctrl_mode` that are set in the data. A write to index 7 sets them.
- R9: In enhanced mode, reads of indices 0 to 11, 13 and 14 return 0x00. Writes to indices 0 to 3 and 5 have no effect. No access changes `sw_latch`, `leg_data` or `leg_mode`.
- R10: Once `enh_mode` is set, it stays set until reset, whatever is accessed.
- R11: A synchronous reset clears `enh_mode`, the detector step, all latches, `leg_data`, `leg_mode`, the phase byte and `ctrl_mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 13 | Byte address within the window |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for the addressed register |
| enh_mode | output | 1 | High once the enhanced map is active |
| sw_latch | output | 8 | Legacy soft-switch latches |
| leg_data | output | 8 | Legacy data register |
| leg_mode | output | 8 | Legacy mode register |
| ctrl_mode | output | 8 | Enhanced control byte |

## Verification
In legacy mode, a single write to index 15 both sets Q7 and is judged as a candidate mode write in the same cycle. The bench therefore starts the unlock sequence with Q7 cleared, so that the first captured write depends on this same-cycle update. The fourth matching write also changes the map on the edge where it is captured, and the access that follows is decoded under the enhanced map. A reference model applies the latch update first, then the capture rule, then the map change, and every output is compared with it on every clock.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    localparam int ADDR_W      = 13;
    localparam int IDX_SHIFT   = 9;
    localparam int IDX_W       = ADDR_W - IDX_SHIFT;
    localparam int DATA_W      = 8;
    localparam int NUM_LATCH   = 8;
    localparam int LSEL_W      = $clog2(NUM_LATCH);
    localparam int UNLOCK_LEN  = 4;
    localparam int STEP_W      = $clog2(UNLOCK_LEN);

    localparam logic [DATA_W-1:0] DRV_PRESENT_Q = 8'h77;
    localparam logic [DATA_W-1:0] SENSE_FLAG    = 8'h08;

    typedef enum logic [LSEL_W-1:0] {
        LT_PH0    = 3'd0,
        LT_PH1    = 3'd1,
        LT_PH2    = 3'd2,
        LT_PH3    = 3'd3,
        LT_MOTOR  = 3'd4,
        LT_DRVSEL = 3'd5,
        LT_Q6     = 3'd6,
        LT_Q7     = 3'd7
    } latch_e;

    typedef enum logic [IDX_W-1:0] {
        EW_DATA   = 4'd0,
        EW_MARK   = 4'd1,
        EW_CRC    = 4'd2,
        EW_PARAM  = 4'd3,
        EW_PHASE  = 4'd4,
        EW_SETUP  = 4'd5,
        EW_MCLR   = 4'd6,
        EW_MSET   = 4'd7,
        ER_DATA   = 4'd8,
        ER_MARK   = 4'd9,
        ER_ERROR  = 4'd10,
        ER_PARAM  = 4'd11,
        ER_PHASE  = 4'd12,
        ER_SETUP  = 4'd13,
        ER_STATUS = 4'd14,
        ER_HSHK   = 4'd15
    } enh_idx_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
    } access_t;

    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] addr);
        return addr[ADDR_W-1:IDX_SHIFT];
    endfunction

    function automatic logic [DATA_W-1:0] unlock_code(input logic [STEP_W-1:0] step);
        logic [DATA_W-1:0] code;
        case (step)
            2'd1:    code = 8'h17;
            default: code = 8'h57;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/fdc_legacy_latches.sv
module fdc_legacy_latches
    import fdc_pkg::*;
#(
    parameter int N_LATCH = NUM_LATCH,
    parameter int DW      = DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  access_t            acc,
    input  logic               legacy_en,
    output logic [N_LATCH-1:0] latch_q,
    output logic               mode_we,
    output logic [DW-1:0]      data_q,
    output logic [DW-1:0]      mode_q
);

    logic [N_LATCH-1:0] latch_nxt;
    logic               hit;
    logic               cap_we;
    logic               data_we;

    assign hit = acc.valid && legacy_en;

    always_comb begin
        latch_nxt = latch_q;
        if (hit) begin
            latch_nxt[acc.idx[IDX_W-1:1]] = acc.idx[0];
        end
    end

    generate
        for (genvar g = 0; g < N_LATCH; g++) begin : g_latch
            always_ff @(posedge clk) begin
                if (rst) begin
                    latch_q[g] <= 1'b0;
                end else if (hit && (acc.idx[IDX_W-1:1] == g[LSEL_W-1:0])) begin
                    latch_q[g] <= latch_nxt[g];
                end
            end
        end
    endgenerate

    // The capture decision sees the latch values after this access's update.
    assign cap_we  = hit && acc.write && latch_nxt[LT_Q6] && latch_nxt[LT_Q7];
    assign data_we = cap_we && latch_nxt[LT_MOTOR];
    assign mode_we = cap_we && !latch_nxt[LT_MOTOR];

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            mode_q <= '0;
        end else begin
            if (data_we) data_q <= acc.wdata;
            if (mode_we) mode_q <= acc.wdata;
        end
    end

endmodule

// File: rtl/fdc_unlock_detect.sv
module fdc_unlock_detect
    import fdc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_en,
    input  logic [DW-1:0] value,
    output logic          unlocked
);

    logic [STEP_W-1:0] step_q;
    logic              match;
    logic              last;

    assign match = (value == unlock_code(step_q));
    assign last  = (step_q == STEP_W'(UNLOCK_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q   <= '0;
            unlocked <= 1'b0;
        end else if (step_en && match) begin
            if (last) begin
                step_q   <= '0;
                unlocked <= 1'b1;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fdc_enh_regs.sv
module fdc_enh_regs
    import fdc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enh_en,
    input  access_t       acc,
    output logic [DW-1:0] phase_q,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] rd_q
);

    logic wr;

    assign wr = enh_en && acc.valid && acc.write;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            ctrl_q  <= '0;
        end else if (wr) begin
            case (enh_idx_e'(acc.idx))
                EW_PHASE: phase_q <= acc.wdata;
                EW_MCLR:  ctrl_q  <= ctrl_q & ~acc.wdata;
                EW_MSET:  ctrl_q  <= ctrl_q | acc.wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_q = '0;
        case (enh_idx_e'(acc.idx))
            ER_PHASE: rd_q = phase_q;
            ER_HSHK:  rd_q = (phase_q == DRV_PRESENT_Q) ? SENSE_FLAG : '0;
            default:  rd_q = '0;
        endcase
    end

endmodule

// File: rtl/fdc_regfront.sv
module fdc_regfront
    import fdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              enh_mode,
    output logic [NUM_LATCH-1:0] sw_latch,
    output logic [DATA_W-1:0] leg_data,
    output logic [DATA_W-1:0] leg_mode,
    output logic [DATA_W-1:0] ctrl_mode
);

    access_t           acc;
    logic              mode_we;
    logic [DATA_W-1:0] phase_q;
    logic [DATA_W-1:0] enh_rd;

    assign acc.valid = acc_valid;
    assign acc.write = acc_write;
    assign acc.idx   = idx_of(acc_addr);
    assign acc.wdata = acc_wdata;

    fdc_legacy_latches #(.N_LATCH(NUM_LATCH), .DW(DATA_W)) u_legacy (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .legacy_en (!enh_mode),
        .latch_q   (sw_latch),
        .mode_we   (mode_we),
        .data_q    (leg_data),
        .mode_q    (leg_mode)
    );

    fdc_unlock_detect #(.DW(DATA_W)) u_unlock (
        .clk      (clk),
        .rst      (rst),
        .step_en  (mode_we),
        .value    (acc_wdata),
        .unlocked (enh_mode)
    );

    fdc_enh_regs #(.DW(DATA_W)) u_enh (
        .clk     (clk),
        .rst     (rst),
        .enh_en  (enh_mode),
        .acc     (acc),
        .phase_q (phase_q),
        .ctrl_q  (ctrl_mode),
        .rd_q    (enh_rd)
    );

    assign rd_data = enh_mode ? enh_rd : '0;

endmodule

// File: rtl/fdc_regfront_chk.sv
module fdc_regfront_chk
    import fdc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              enh_mode,
    input logic [NUM_LATCH-1:0] sw_latch,
    input logic [DATA_W-1:0] leg_data,
    input logic [DATA_W-1:0] leg_mode,
    input logic [DATA_W-1:0] ctrl_mode
);

    logic [IDX_W-1:0] idx;
    assign idx = acc_addr[ADDR_W-1:IDX_SHIFT];

    assert_legacy_rd_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !enh_mode |-> rd_data == '0);

    assert_unlock_on_code_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(enh_mode) |-> $past(acc_valid && acc_write && acc_wdata == 8'h57));

    assert_hshk_values_R7: assert property (@(posedge clk) disable iff (rst)
        (enh_mode && idx == 4'd15) |-> (rd_data == 8'h08 || rd_data == 8'h00));

    assert_mset_bits_R8: assert property (@(posedge clk) disable iff (rst)
        (enh_mode && acc_valid && acc_write && idx == 4'd7)
        |=> ((ctrl_mode & $past(acc_wdata)) == $past(acc_wdata)));

    assert_mclr_bits_R8: assert property (@(posedge clk) disable iff (rst)
        (enh_mode && acc_valid && acc_write && idx == 4'd6)
        |=> ((ctrl_mode & $past(acc_wdata)) == '0));

    assert_latch_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        enh_mode |=> ($stable(sw_latch) && $stable(leg_data) && $stable(leg_mode)));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        enh_mode |=> enh_mode);

    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> (!enh_mode && sw_latch == '0 && ctrl_mode == '0
                 && leg_data == '0 && leg_mode == '0));

endmodule

bind fdc_regfront fdc_regfront_chk u_chk (.*);

// File: tb/tb_fdc_regfront.sv
module tb_fdc_regfront;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [12:0] acc_addr  = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  rd_data;
    logic        enh_mode;
    logic [7:0]  sw_latch;
    logic [7:0]  leg_data;
    logic [7:0]  leg_mode;
    logic [7:0]  ctrl_mode;

    int n_chk  = 0;
    int n_fail = 0;

    fdc_regfront dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
        .enh_mode(enh_mode), .sw_latch(sw_latch), .leg_data(leg_data),
        .leg_mode(leg_mode), .ctrl_mode(ctrl_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    bit       m_latch [8];
    int       m_step;
    bit       m_enh;
    int       m_phase, m_ctrl, m_ldata, m_lmode;
    int       code_q [$] = '{8'h57, 8'h17, 8'h57, 8'h57};

    function automatic int m_latch_byte();
        int v = 0;
        for (int i = 0; i < 8; i++) if (m_latch[i]) v += (1 << i);
        return v;
    endfunction

    function automatic int m_read(input int idx);
        if (!m_enh) return 0;
        if (idx == 12) return m_phase;
        if (idx == 15) return (m_phase == 'h77) ? 8 : 0;
        return 0;
    endfunction

    always @(posedge clk) begin
        int idx;
        idx = int'(acc_addr) / 512;
        if (rst) begin
            for (int i = 0; i < 8; i++) m_latch[i] = 0;
            m_step = 0; m_enh = 0; m_phase = 0; m_ctrl = 0; m_ldata = 0; m_lmode = 0;
        end else if (acc_valid) begin
            if (!m_enh) begin
                m_latch[idx / 2] = (idx % 2) == 1;
                if (acc_write && m_latch[6] && m_latch[7]) begin
                    if (m_latch[4]) m_ldata = int'(acc_wdata);
                    else begin
                        m_lmode = int'(acc_wdata);
                        if (int'(acc_wdata) == code_q[m_step]) begin
                            if (m_step == 3) begin m_enh = 1; m_step = 0; end
                            else m_step++;
                        end
                    end
                end
            end else if (acc_write) begin
                if (idx == 4) m_phase = int'(acc_wdata);
                else if (idx == 6) m_ctrl = m_ctrl & ~int'(acc_wdata) & 'hFF;
                else if (idx == 7) m_ctrl = (m_ctrl | int'(acc_wdata)) & 'hFF;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, after the edge and before the next input change
    always @(posedge clk) begin
        #(CLK_PERIOD/2 - 1);
        begin
            int idx;
            int er;
            string rq;
            idx = int'(acc_addr) / 512;
            er = m_read(idx);
            rq = !m_enh ? "R3" : (idx == 12 ? "R6" : (idx == 15 ? "R7" : "R9"));
            chk(int'(rd_data) == er, rq, int'(rd_data), er);
            chk(int'(sw_latch) == m_latch_byte(), "R2", int'(sw_latch), m_latch_byte());
            chk(enh_mode == m_enh, "R5", int'(enh_mode), int'(m_enh));
            chk(int'(leg_data) == m_ldata, "R4", int'(leg_data), m_ldata);
            chk(int'(leg_mode) == m_lmode, "R4", int'(leg_mode), m_lmode);
            chk(int'(ctrl_mode) == m_ctrl, "R8", int'(ctrl_mode), m_ctrl);
        end
    end

    task automatic access(input bit wr, input int idx, input int low, input int data);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_addr  = 13'((idx << 9) | (low & 'h1FF));
        acc_wdata = 8'(data);
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    task automatic rd(input int idx, output int val);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = 1'b0;
        acc_addr  = 13'(idx << 9);
        #1 val = int'(rd_data);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(enh_mode == 0 && sw_latch == 0 && ctrl_mode == 0, "R11", int'(sw_latch), 0);

        // R1/R2/R3: soft switches from every index, low address bits junk
        for (int i = 0; i < 16; i++) access(i % 2, i, i * 37 + 5, 'hA0 + i);
        access(0, 13, 'h1FF, 0);
        chk(sw_latch[6] == 1'b1, "R1", int'(sw_latch[6]), 1);
        access(0, 12, 'h155, 0);
        chk(sw_latch[6] == 1'b0, "R1", int'(sw_latch[6]), 0);

        // R4: Q6 clear, Q7 set -> writes ignored
        for (int i = 0; i < 4; i++) access(1, 15, 0, code_q[i]);
        chk(enh_mode == 0 && leg_mode == 0, "R4", int'(leg_mode), 0);

        // R4: motor on -> data register, no unlock
        access(0, 9, 0, 0);
        access(0, 13, 0, 0);
        for (int i = 0; i < 4; i++) access(1, 15, 0, code_q[i]);
        chk(enh_mode == 0 && leg_data == 8'h57, "R4", int'(leg_data), 'h57);

        // R5: motor off, Q7 cleared so the first write sets it in the same cycle
        access(0, 8, 0, 0);
        access(0, 14, 0, 0);
        access(1, 15, 0, 'h57);
        access(1, 15, 0, 'h00);
        access(1, 15, 0, 'h17);
        access(1, 15, 0, 'h33);
        access(1, 15, 0, 'h57);
        chk(enh_mode == 0, "R5", int'(enh_mode), 0);
        access(1, 15, 0, 'h57);
        chk(enh_mode == 1, "R5", int'(enh_mode), 1);

        // R6/R7
        access(1, 4, 'h3, 'h77);
        rd(12, v); chk(v == 'h77, "R6", v, 'h77);
        rd(15, v); chk(v == 'h08, "R7", v, 'h08);
        access(1, 4, 0, 'h76);
        rd(15, v); chk(v == 0, "R7", v, 0);

        // R8
        access(1, 7, 0, 'hA5);
        access(1, 6, 0, 'h21);
        chk(ctrl_mode == 8'h84, "R8", int'(ctrl_mode), 'h84);

        // R9: unimplemented writes and reads, latches frozen
        v = int'(sw_latch);
        foreach (code_q[k]) access(1, k, 0, 'hFF);
        access(1, 5, 0, 'hFF);
        access(0, 9, 0, 0);
        chk(ctrl_mode == 8'h84 && int'(sw_latch) == v, "R9", int'(ctrl_mode), 'h84);
        for (int i = 0; i < 15; i++) begin
            int r;
            if (i == 12) continue;
            rd(i, r); chk(r == 0, "R9", r, 0);
        end

        // R10: legacy-style traffic does not leave enhanced mode
        for (int i = 0; i < 8; i++) access(1, 15 - i, 0, 'h57);
        chk(enh_mode == 1, "R10", int'(enh_mode), 1);

        // R11: reset from enhanced mode
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(enh_mode == 0 && ctrl_mode == 0 && leg_data == 0 && sw_latch == 0,
            "R11", int'(enh_mode), 0);
        rd(12, v); chk(v == 0, "R11", v, 0);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule